// File: doc/BRIEF.md
# Multi-Channel Block Transfer Engine

This block moves blocks of words from device controllers toward memory with no processor involvement between the start and the end of a block. Several channels run side by side. Each one is programmed by a single configuration write that carries the transfer direction, the device it serves, the word count, the first memory address and the bus-ownership mode. The write also starts the channel.

A started channel first asks its device to load and check a buffer. Once the device reports that the buffer is ready, the channel joins the set of channels that are moving words. A single shared mover serves that set in rotating order. For each word the mover raises a request to the channel's device, presents the memory address and direction, and waits for that device's own acknowledge line.

When the count runs out, the channel reports completion and holds its interrupt until the processor clears it. For bus ownership, each channel chooses one of two modes. In stealing mode the bus is requested once per word. In block mode the bus is requested once and kept until the whole block has moved.

Top module: `multi_dma`

## Requirements
- R1: After reset every channel status reads idle (code 0), and irq_o, fill_req_o, xfer_req_o and bus_req_o are all low.
- R2: A write with a nonzero count puts the channel into the filling state (code 1) on the next cycle. While filling, the channel drives fill_req_o at the bit of its device number. It moves to the transferring state (code 2) after fill_done_i for that device is seen high.
- R3: Each word raises exactly one xfer_req_o bit, the one for the channel's device. mem_addr_o equals the start address plus the number of words already moved, modulo 2^AW. A word counts when dev_ack_i of that device is high while the request is up. Exactly the programmed number of words is moved.
- R4: The cycle after the last word is acknowledged, the status reads done (code 3) and that channel's irq_o bit is high. A pulse on its irq_clr_i bit returns the channel to idle and drops the interrupt.
- R5: A write with count 0 reads done with the interrupt high on the next cycle. It produces no fill request and no bus request.
- R6: In stealing mode (cfg_block_i = 0), bus_req_o is low in the cycle after each acknowledged word, so the bus is requested once per word.
- R7: In block mode (cfg_block_i = 1), bus_req_o stays high from the first request until the last word of the block, so the bus is requested once per block.
- R8: After serving a channel, the mover next serves the first transferring channel in rotating index order that follows it. When all channels have equal counts and start together, the served channel index therefore rises by one, modulo the channel count, on every word.
- R9: A configuration write to a channel that is filling or transferring is ignored, including one that lands in the same cycle as its last acknowledge. Its device, count, address and direction are unchanged. Writes to idle or done channels are accepted.
- R10: mem_dir_o equals the direction programmed for the channel whose word is being requested.
- R11: No word request is raised before bus_gnt_i is seen high for the current ownership, and xfer_req_o is never high while bus_req_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe that programs and starts a channel |
| cfg_ch_i | input | CHW | Channel selected by the write |
| cfg_dir_i | input | 1 | Transfer direction for the channel |
| cfg_block_i | input | 1 | 1 = block ownership, 0 = stealing ownership |
| cfg_port_i | input | PW | Device number bound to the channel |
| cfg_cnt_i | input | CW | Number of words in the block |
| cfg_addr_i | input | AW | First memory address |
| irq_clr_i | input | NCH | Per-channel interrupt clear |
| status_o | output | 2*NCH | Per-channel state code, two bits per channel |
| irq_o | output | NCH | Per-channel completion interrupt |
| fill_req_o | output | NDEV | Per-device request to load and check a buffer |
| fill_done_i | input | NDEV | Per-device buffer-ready indication |
| bus_req_o | output | 1 | Bus ownership request |
| bus_gnt_i | input | 1 | Bus ownership grant |
| xfer_req_o | output | NDEV | Per-device word request |
| dev_ack_i | input | NDEV | Per-device word acknowledge |
| mem_addr_o | output | AW | Memory address of the current word |
| mem_dir_o | output | 1 | Direction of the current word |

## Verification
The two functions that collide are the mover's completion of a channel and a processor configuration write to that same channel. Both change the channel's registers at one clock edge. The bench provokes this by watching for the final acknowledge of a block-mode channel and placing a fresh configuration write in that same cycle. The result is judged correct only if the channel reads done with its interrupt high, no further word request ever appears for its device, and its next write after the interrupt clear is accepted. A second overlap appears when four channels start together in stealing mode: the bench then checks that each new grant moves to the next channel index while the others keep their addresses.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {
    CH_IDLE = 2'd0,
    CH_FILL = 2'd1,
    CH_MOVE = 2'd2,
    CH_DONE = 2'd3
  } ch_state_e;

  typedef enum logic [1:0] {
    EN_IDLE = 2'd0,
    EN_BUS  = 2'd1,
    EN_WORD = 2'd2
  } eng_state_e;
endpackage

// File: rtl/dma_chan.sv
module dma_chan
  import dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 8,
  parameter int PW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic          dir_i,
  input  logic          block_i,
  input  logic [PW-1:0] port_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [AW-1:0] addr_i,
  input  logic          clr_i,
  input  logic          fill_done_i,
  input  logic          word_ack_i,
  output ch_state_e     state_o,
  output logic [PW-1:0] port_o,
  output logic [AW-1:0] addr_o,
  output logic          dir_o,
  output logic          block_o,
  output logic          last_o
);
  ch_state_e     state_q, state_d;
  logic [PW-1:0] port_q, port_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          dir_q, dir_d, block_q, block_d;
  logic          accept, data_en;

  assign accept  = wr_i && (state_q == CH_IDLE || state_q == CH_DONE);
  assign data_en = accept || word_ack_i;

  always_comb begin
    state_d = state_q;
    port_d  = port_q;
    addr_d  = addr_q;
    cnt_d   = cnt_q;
    dir_d   = dir_q;
    block_d = block_q;
    case (state_q)
      CH_IDLE, CH_DONE: begin
        if (accept) begin
          port_d  = port_i;
          addr_d  = addr_i;
          cnt_d   = cnt_i;
          dir_d   = dir_i;
          block_d = block_i;
          state_d = (cnt_i == '0) ? CH_DONE : CH_FILL;
        end else if (state_q == CH_DONE && clr_i) begin
          state_d = CH_IDLE;
        end
      end
      CH_FILL: if (fill_done_i) state_d = CH_MOVE;
      CH_MOVE: begin
        if (word_ack_i) begin
          addr_d = addr_q + AW'(1);
          cnt_d  = cnt_q - CW'(1);
          if (cnt_q == CW'(1)) state_d = CH_DONE;
        end
      end
      default: state_d = CH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CH_IDLE;
      port_q  <= '0;
      addr_q  <= '0;
      cnt_q   <= '0;
      dir_q   <= 1'b0;
      block_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (data_en) begin
        port_q  <= port_d;
        addr_q  <= addr_d;
        cnt_q   <= cnt_d;
        dir_q   <= dir_d;
        block_q <= block_d;
      end
    end
  end

  assign state_o = state_q;
  assign port_o  = port_q;
  assign addr_o  = addr_q;
  assign dir_o   = dir_q;
  assign block_o = block_q;
  assign last_o  = (cnt_q == CW'(1));

  assert_zero_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cnt_i == '0) |=> (state_q == CH_DONE));
  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && state_q == CH_FILL) |=> ($stable(addr_q) && $stable(cnt_q) && $stable(port_q)));
  assert_ack_in_move_R3: assert property (@(posedge clk) disable iff (!rst_n)
    word_ack_i |-> (state_q == CH_MOVE));
  assert_last_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (word_ack_i && last_o) |=> (state_q == CH_DONE));
endmodule

// File: rtl/dma_rr_arb.sv
module dma_rr_arb #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_i,
  input  logic          take_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  logic [IW-1:0] ptr_q;

  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int k = 1; k <= N; k++) begin
      if (!valid_o && req_i[(int'(ptr_q) + k) % N]) begin
        valid_o = 1'b1;
        idx_o   = IW'((int'(ptr_q) + k) % N);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= IW'(N - 1);
    else if (take_i) ptr_q <= idx_o;
  end

  assert_pick_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |-> (valid_o && req_i[idx_o]));
  assert_ptr_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> (ptr_q == $past(idx_o)));
endmodule

// File: rtl/dma_mover.sv
module dma_mover
  import dma_pkg::*;
#(
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_valid_i,
  input  logic [IW-1:0] sel_idx_i,
  input  logic          block_i,
  input  logic          last_i,
  input  logic          gnt_i,
  input  logic          ack_i,
  output logic          take_o,
  output logic [IW-1:0] cur_o,
  output logic          bus_req_o,
  output logic          word_req_o,
  output logic          word_done_o
);
  eng_state_e    state_q, state_d;
  logic [IW-1:0] cur_q, cur_d;

  always_comb begin
    state_d = state_q;
    cur_d   = cur_q;
    take_o  = 1'b0;
    case (state_q)
      EN_IDLE: begin
        if (sel_valid_i) begin
          take_o  = 1'b1;
          cur_d   = sel_idx_i;
          state_d = EN_BUS;
        end
      end
      EN_BUS:  if (gnt_i) state_d = EN_WORD;
      EN_WORD: if (ack_i && (last_i || !block_i)) state_d = EN_IDLE;
      default: state_d = EN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= EN_IDLE;
      cur_q   <= '0;
    end else begin
      state_q <= state_d;
      if (take_o) cur_q <= cur_d;
    end
  end

  assign cur_o       = cur_q;
  assign bus_req_o   = (state_q != EN_IDLE);
  assign word_req_o  = (state_q == EN_WORD);
  assign word_done_o = word_req_o && ack_i;

  assert_steal_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done_o && !block_i) |=> !bus_req_o);
  assert_block_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done_o && block_i && !last_i) |=> (bus_req_o && word_req_o));
  assert_wait_grant_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && !word_req_o && !gnt_i) |=> !word_req_o);
endmodule

// File: rtl/multi_dma.sv
module multi_dma
  import dma_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int NDEV = 4,
  parameter int AW   = 16,
  parameter int CW   = 8,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int PW  = (NDEV > 1) ? $clog2(NDEV) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we_i,
  input  logic [CHW-1:0]   cfg_ch_i,
  input  logic             cfg_dir_i,
  input  logic             cfg_block_i,
  input  logic [PW-1:0]    cfg_port_i,
  input  logic [CW-1:0]    cfg_cnt_i,
  input  logic [AW-1:0]    cfg_addr_i,
  input  logic [NCH-1:0]   irq_clr_i,
  output logic [2*NCH-1:0] status_o,
  output logic [NCH-1:0]   irq_o,
  output logic [NDEV-1:0]  fill_req_o,
  input  logic [NDEV-1:0]  fill_done_i,
  output logic             bus_req_o,
  input  logic             bus_gnt_i,
  output logic [NDEV-1:0]  xfer_req_o,
  input  logic [NDEV-1:0]  dev_ack_i,
  output logic [AW-1:0]    mem_addr_o,
  output logic             mem_dir_o
);
  logic rst_meta, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_s, rst_meta} <= 2'b00;
    else        {rst_s, rst_meta} <= {rst_meta, 1'b1};
  end

  ch_state_e     st_w    [NCH];
  logic [PW-1:0] port_w  [NCH];
  logic [AW-1:0] addr_w  [NCH];
  logic          dir_w   [NCH];
  logic          block_w [NCH];
  logic          last_w  [NCH];
  logic [NCH-1:0] move_vec, done_vec;
  logic           sel_valid, take, word_req, word_done;
  logic [CHW-1:0] sel_idx, cur;
  logic [PW-1:0]  cur_port;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dma_chan #(.AW(AW), .CW(CW), .PW(PW)) i_chan (
      .clk        (clk),
      .rst_n      (rst_s),
      .wr_i       (cfg_we_i && cfg_ch_i == CHW'(g)),
      .dir_i      (cfg_dir_i),
      .block_i    (cfg_block_i),
      .port_i     (cfg_port_i),
      .cnt_i      (cfg_cnt_i),
      .addr_i     (cfg_addr_i),
      .clr_i      (irq_clr_i[g]),
      .fill_done_i(fill_done_i[port_w[g]]),
      .word_ack_i (word_done && cur == CHW'(g)),
      .state_o    (st_w[g]),
      .port_o     (port_w[g]),
      .addr_o     (addr_w[g]),
      .dir_o      (dir_w[g]),
      .block_o    (block_w[g]),
      .last_o     (last_w[g])
    );
    assign status_o[2*g +: 2] = st_w[g];
    assign move_vec[g]        = (st_w[g] == CH_MOVE);
    assign done_vec[g]        = (st_w[g] == CH_DONE);
  end

  assign irq_o = done_vec;

  always_comb begin
    fill_req_o = '0;
    for (int c = 0; c < NCH; c++) begin
      if (st_w[c] == CH_FILL) fill_req_o[port_w[c]] = 1'b1;
    end
  end

  dma_rr_arb #(.N(NCH), .IW(CHW)) i_arb (
    .clk    (clk),
    .rst_n  (rst_s),
    .req_i  (move_vec),
    .take_i (take),
    .valid_o(sel_valid),
    .idx_o  (sel_idx)
  );

  assign cur_port = port_w[cur];

  dma_mover #(.IW(CHW)) i_mover (
    .clk        (clk),
    .rst_n      (rst_s),
    .sel_valid_i(sel_valid),
    .sel_idx_i  (sel_idx),
    .block_i    (block_w[cur]),
    .last_i     (last_w[cur]),
    .gnt_i      (bus_gnt_i),
    .ack_i      (dev_ack_i[cur_port]),
    .take_o     (take),
    .cur_o      (cur),
    .bus_req_o  (bus_req_o),
    .word_req_o (word_req),
    .word_done_o(word_done)
  );

  assign xfer_req_o = word_req ? (NDEV'(1) << cur_port) : '0;
  assign mem_addr_o = addr_w[cur];
  assign mem_dir_o  = dir_w[cur];

  assert_one_word_R3: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0(xfer_req_o));
  assert_word_needs_bus_R11: assert property (@(posedge clk) disable iff (!rst_s)
    (|xfer_req_o) |-> bus_req_o);
  assert_serve_moving_R8: assert property (@(posedge clk) disable iff (!rst_s)
    word_req |-> move_vec[cur]);
endmodule

// File: tb/test_multi_dma.sv
`timescale 1ns/1ps
module test_multi_dma;
  localparam int NCH = 4, NDEV = 4, AW = 16, CW = 8;
  localparam time CYC = 20ns;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cfg_we;
  logic [1:0]       cfg_ch;
  logic             cfg_dir, cfg_block;
  logic [1:0]       cfg_port;
  logic [CW-1:0]    cfg_cnt;
  logic [AW-1:0]    cfg_addr;
  logic [NCH-1:0]   irq_clr;
  logic [2*NCH-1:0] status;
  logic [NCH-1:0]   irq;
  logic [NDEV-1:0]  fill_req, fill_done, xfer_req, dev_ack;
  logic             bus_req, bus_gnt, mem_dir;
  logic [AW-1:0]    mem_addr;

  multi_dma #(.NCH(NCH), .NDEV(NDEV), .AW(AW), .CW(CW)) i_multi_dma (
    .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we), .cfg_ch_i(cfg_ch),
    .cfg_dir_i(cfg_dir), .cfg_block_i(cfg_block), .cfg_port_i(cfg_port),
    .cfg_cnt_i(cfg_cnt), .cfg_addr_i(cfg_addr), .irq_clr_i(irq_clr),
    .status_o(status), .irq_o(irq), .fill_req_o(fill_req), .fill_done_i(fill_done),
    .bus_req_o(bus_req), .bus_gnt_i(bus_gnt), .xfer_req_o(xfer_req),
    .dev_ack_i(dev_ack), .mem_addr_o(mem_addr), .mem_dir_o(mem_dir)
  );

  always #(CYC/2) clk = ~clk;

  int n_vec = 0, n_bad = 0;
  bit finished = 1'b0;
  bit fill_en = 1'b1, bus_hold = 1'b0, bus_prev = 1'b0;
  int rises = 0;
  int exp_left [NDEV];
  logic [AW-1:0] exp_next [NDEV];
  logic exp_dir [NDEV];
  int served [64];
  int n_served = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Device, fill and bus-grant models, driven away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      for (int d = 0; d < NDEV; d++) begin
        if (dev_ack[d]) dev_ack[d] = 1'b0;
        else if (xfer_req[d]) begin
          chk(exp_left[d] > 0, "R3 word count", exp_left[d], 1);
          chk(mem_addr == exp_next[d], "R3 address", mem_addr, exp_next[d]);
          chk(mem_dir == exp_dir[d], "R10 direction", mem_dir, exp_dir[d]);
          exp_next[d] = exp_next[d] + 1'b1;
          exp_left[d] = exp_left[d] - 1;
          if (n_served < 64) served[n_served] = d;
          n_served++;
          dev_ack[d] = 1'b1;
        end
        fill_done[d] = fill_req[d] && fill_en;
      end
      if (bus_req && !bus_prev) rises++;
      bus_prev = bus_req;
      bus_gnt  = bus_req && !bus_hold;
    end
  end

  function automatic logic [1:0] st(input int ch);
    return status[2*ch +: 2];
  endfunction

  task automatic program_ch(input int ch, input int port, input bit blk, input int cnt,
                            input logic [AW-1:0] addr, input bit dir);
    cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_port = 2'(port); cfg_block = blk;
    cfg_cnt = CW'(cnt); cfg_addr = addr; cfg_dir = dir;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic expect_dev(input int port, input int cnt, input logic [AW-1:0] addr, input bit dir);
    exp_left[port] = cnt; exp_next[port] = addr; exp_dir[port] = dir;
  endtask

  task automatic wait_irq(input int ch, input string req);
    int t = 0;
    while (!irq[ch] && t < 600) begin @(negedge clk); t++; end
    chk(irq[ch], req, irq[ch], 1);
  endtask

  task automatic clear_irq(input int ch);
    irq_clr[ch] = 1'b1;
    @(negedge clk);
    irq_clr[ch] = 1'b0;
    chk(st(ch) == 2'd0, "R4 clear to idle", st(ch), 0);
    chk(irq[ch] == 1'b0, "R4 irq dropped", irq[ch], 0);
  endtask

  task automatic run_one(input int ch, input int port, input bit blk, input int cnt,
                         input logic [AW-1:0] addr, input bit dir);
    int want_rises;
    expect_dev(port, cnt, addr, dir);
    rises = 0;
    program_ch(ch, port, blk, cnt, addr, dir);
    if (cnt == 0) begin
      chk(st(ch) == 2'd3 && irq[ch], "R5 zero count done", st(ch), 3);
      chk(fill_req == '0 && !bus_req, "R5 no fill or bus", {fill_req, bus_req}, 0);
    end else begin
      chk(st(ch) == 2'd1, "R2 filling state", st(ch), 1);
      chk(fill_req == NDEV'(1 << port), "R2 fill request device", fill_req, 1 << port);
    end
    wait_irq(ch, "R4 interrupt raised");
    chk(st(ch) == 2'd3, "R4 done state", st(ch), 3);
    chk(exp_left[port] == 0, "R3 all words moved", exp_left[port], 0);
    want_rises = (cnt == 0) ? 0 : (blk ? 1 : cnt);
    chk(rises == want_rises, blk ? "R7 one bus request per block" : "R6 one bus request per word",
        rises, want_rises);
    clear_irq(ch);
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_ch = '0; cfg_dir = 1'b0; cfg_block = 1'b0;
    cfg_port = '0; cfg_cnt = '0; cfg_addr = '0; irq_clr = '0;
    fill_done = '0; dev_ack = '0; bus_gnt = 1'b0;
    for (int d = 0; d < NDEV; d++) begin exp_left[d] = 0; exp_next[d] = '0; exp_dir[d] = 1'b0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(status == '0, "R1 status idle", status, 0);
    chk(irq == '0 && fill_req == '0 && xfer_req == '0 && !bus_req, "R1 outputs quiet",
        {irq, fill_req, xfer_req, bus_req}, 0);

    // Sweep over channel, mode and count, with address wrap
    for (int ch = 0; ch < NCH; ch++)
      for (int blk = 0; blk < 2; blk++)
        for (int cnt = 0; cnt < 6; cnt++)
          run_one(ch, (ch + 1) % NDEV, blk[0], cnt, AW'(16'hFFFD + ch * 7 + cnt * 3), cnt[0]);

    // R8 rotation: four channels ready in the same cycle, stealing mode
    fill_en = 1'b0;
    n_served = 0;
    for (int ch = 0; ch < NCH; ch++) begin
      expect_dev(ch, 3, AW'(16'h0400 + ch * 16'h0100), ch[0]);
      program_ch(ch, ch, 1'b0, 3, AW'(16'h0400 + ch * 16'h0100), ch[0]);
    end
    fill_en = 1'b1;
    for (int ch = 0; ch < NCH; ch++) wait_irq(ch, "R4 interrupt in rotation");
    chk(n_served == 12, "R8 words served", n_served, 12);
    for (int k = 1; k < 12; k++)
      chk(served[k] == (served[0] + k) % NCH, "R8 round robin order", served[k], (served[0] + k) % NCH);
    for (int ch = 0; ch < NCH; ch++) clear_irq(ch);

    // R9 and R11: writes to a busy channel, word request held off by the grant
    fill_en = 1'b0;
    expect_dev(3, 3, 16'h0100, 1'b1);
    expect_dev(0, 0, 16'h0000, 1'b0);
    program_ch(2, 3, 1'b0, 3, 16'h0100, 1'b1);
    program_ch(2, 0, 1'b1, 6, 16'h0900, 1'b0);
    chk(st(2) == 2'd1, "R9 still filling", st(2), 1);
    chk(fill_req == 4'b1000, "R9 device unchanged", fill_req, 4'b1000);
    bus_hold = 1'b1;
    fill_en = 1'b1;
    repeat (4) @(negedge clk);
    chk(st(2) == 2'd2, "R2 transferring state", st(2), 2);
    chk(bus_req && xfer_req == '0, "R11 no word without grant", {bus_req, xfer_req}, 5'b10000);
    program_ch(2, 0, 1'b1, 6, 16'h0900, 1'b0);
    bus_hold = 1'b0;
    wait_irq(2, "R4 interrupt after ignored writes");
    chk(exp_left[3] == 0, "R9 original count kept", exp_left[3], 0);
    chk(exp_next[3] == 16'h0103, "R9 original address kept", exp_next[3], 16'h0103);
    clear_irq(2);

    // R9 collision: write lands in the cycle of the last acknowledge
    begin
      int t = 0;
      expect_dev(1, 2, 16'h2000, 1'b0);
      program_ch(1, 1, 1'b1, 2, 16'h2000, 1'b0);
      forever begin
        @(negedge clk); #1;
        t++;
        if ((dev_ack[1] && exp_left[1] == 0) || t > 200) break;
      end
      cfg_we = 1'b1; cfg_ch = 2'd1; cfg_port = 2'd1; cfg_block = 1'b1;
      cfg_cnt = 8'd4; cfg_addr = 16'h3000; cfg_dir = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
      chk(st(1) == 2'd3 && irq[1], "R9 last-ack write dropped, done", st(1), 3);
      repeat (10) @(negedge clk);
      chk(xfer_req == '0 && exp_left[1] == 0, "R9 no extra words", xfer_req, 0);
      clear_irq(1);
      run_one(1, 2, 1'b0, 2, 16'h3000, 1'b1);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(CYC * 150000);
    if (!finished) begin
      chk(1'b0, "watchdog expired", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule